// File: doc/BRIEF.md
# Multi-Channel Servo Pulse Generator

This block drives a bank of hobby servo outputs from a single 50 MHz clock, so every timing value counts 20 ns ticks. One frame counter is shared by all channels. It counts from zero up to the programmed frame length minus one, then wraps. Each channel compares that count against its own high-time value and drives its output high while the count is below it. A frame length of 1,000,000 ticks gives the usual 20 ms servo frame.

Software sets up the block through a plain synchronous register port with an address, write data, a write strobe and a read-data return. The frame length and the high times are double-buffered. A new value written in the middle of a frame is copied into the working copy only when the frame wraps. An output therefore never shows a shortened or stretched pulse. A configuration word gates the outputs. It holds one enable bit per channel and one global enable that stops the whole bank at once. The register port is a control path and has no flow control. A write always completes in the cycle its strobe is sampled.

Top module: `servo_pwm_bank`

## Requirements
- R1: After reset, every register reads back as zero and every servo output is low.
- R2: Address 0 holds the frame length, address 1 the configuration word, and address 2+n the high time of channel n. Each reads back its last written value combinationally. The configuration word keeps only bits [N_CH:0] and reads the rest as zero. Any other address reads as zero and ignores writes.
- R3: With the global and channel enables set, channel n is high for exactly its high time in ticks at the start of each frame, and the frame repeats every frame-length ticks.
- R4: All channels share one frame counter, so every enabled channel with a nonzero high time rises in the same cycle.
- R5: Configuration bit n enables channel n. While it is clear, that channel's output stays low and the other channels are not affected.
- R6: Configuration bit N_CH is the global enable. When it is cleared, all outputs go low in the next cycle and the frame counter is held at zero. When it is set again, a fresh frame starts from count zero.
- R7: A high time written mid-frame leaves the current frame unchanged and applies from the next frame boundary.
- R8: A high time greater than or equal to the frame length holds the enabled output high for the whole frame.
- R9: A high time of zero keeps the output low.
- R10: A frame length written mid-frame does not shorten or stretch the current frame. It applies from the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| servo_o | output | N_CH | Servo pulse outputs, bit n for channel n |

## Verification
The assertions check on every cycle the properties that can be stated in one cycle:
- channel gating and global gating force outputs low,
- the counter stays below the working frame length,
- the working copies change only at a boundary,
- a zero high time gives no pulse and an oversized high time gives a pulse through the whole frame.

Only the bench scenarios show the exact pulse shapes. These include the high and low tick counts of each frame, and channels rising together. They also cover the deferred effect of a high-time or frame-length write placed at a known count, the frame restarting from zero after a global re-enable, and register readback including the masking of the configuration word.

// File: rtl/servo_pkg.sv
package servo_pkg;
  localparam int unsigned ADDR_PERIOD  = 0;
  localparam int unsigned ADDR_CFG     = 1;
  localparam int unsigned ADDR_ON_BASE = 2;
endpackage

// File: rtl/servo_regs.sv
module servo_regs
  import servo_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         we,
  output logic [DATA_W-1:0]            rdata,
  output logic [DATA_W-1:0]            period_q,
  output logic [N_CH:0]                cfg_q,
  output logic [N_CH-1:0][DATA_W-1:0]  on_q
);
  localparam int CFG_W = N_CH + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cfg_q    <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(ADDR_PERIOD)) period_q <= wdata;
      if (addr == ADDR_W'(ADDR_CFG))    cfg_q    <= wdata[CFG_W-1:0];
    end
  end

  for (genvar n = 0; n < N_CH; n++) begin : g_on
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        on_q[n] <= '0;
      else if (we && addr == ADDR_W'(ADDR_ON_BASE + n))
        on_q[n] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADDR_PERIOD)) rdata = period_q;
    if (addr == ADDR_W'(ADDR_CFG))    rdata = DATA_W'(cfg_q);
    for (int n = 0; n < N_CH; n++)
      if (addr == ADDR_W'(ADDR_ON_BASE + n)) rdata = on_q[n];
  end
endmodule

// File: rtl/servo_frame.sv
module servo_frame #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] period_q,
  output logic [W-1:0] cnt,
  output logic [W-1:0] period_act,
  output logic         load
);
  logic wrap;

  assign wrap = (period_act == '0) || (cnt >= period_act - W'(1));
  assign load = !run || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      period_act <= '0;
    end else if (load) begin
      cnt        <= '0;
      period_act <= period_q;
    end else begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/servo_chan.sv
module servo_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         en,
  input  logic [W-1:0] on_q,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] on_act,
  output logic         pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    on_act <= '0;
    else if (load) on_act <= on_q;
  end

  assign pulse = en && (cnt < on_act);
endmodule

// File: rtl/servo_pwm_bank.sv
module servo_pwm_bank #(
  parameter int N_CH   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_CH-1:0]   servo_o
);
  localparam int GLB_BIT = N_CH;

  logic [DATA_W-1:0]           period_q;
  logic [N_CH:0]               cfg_q;
  logic [N_CH-1:0][DATA_W-1:0] on_q;
  logic [N_CH-1:0][DATA_W-1:0] on_act;
  logic [DATA_W-1:0]           cnt;
  logic [DATA_W-1:0]           period_act;
  logic                        load;
  logic                        glb_en;

  assign glb_en = cfg_q[GLB_BIT];

  servo_regs #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .we       (reg_we),
    .rdata    (reg_rdata),
    .period_q (period_q),
    .cfg_q    (cfg_q),
    .on_q     (on_q)
  );

  servo_frame #(.W(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (glb_en),
    .period_q   (period_q),
    .cnt        (cnt),
    .period_act (period_act),
    .load       (load)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    servo_chan #(.W(DATA_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .en     (glb_en && cfg_q[n]),
      .on_q   (on_q[n]),
      .cnt    (cnt),
      .on_act (on_act[n]),
      .pulse  (servo_o[n])
    );
  end
endmodule

// File: rtl/servo_pwm_bank_chk.sv
module servo_pwm_bank_chk #(
  parameter int N_CH = 8,
  parameter int W    = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_CH-1:0]         servo_o,
  input logic                    glb,
  input logic [N_CH-1:0]         ch_en,
  input logic [W-1:0]            cnt,
  input logic [W-1:0]            period_act,
  input logic [N_CH-1:0][W-1:0]  on_act
);
  assert_glb_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !glb |-> servo_o == '0);

  assert_glb_off_cnt_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !glb |=> cnt == '0);

  assert_chan_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (servo_o & ~ch_en) == '0);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    period_act != '0 |-> cnt < period_act);

  assert_period_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0 |-> $stable(period_act));

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    assert_on_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt != '0 |-> $stable(on_act[n]));

    assert_zero_on_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      on_act[n] == '0 |-> !servo_o[n]);

    assert_full_on_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (glb && ch_en[n] && period_act != '0 && on_act[n] >= period_act) |-> servo_o[n]);
  end
endmodule

bind servo_pwm_bank servo_pwm_bank_chk #(.N_CH(N_CH), .W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .servo_o    (servo_o),
  .glb        (cfg_q[N_CH]),
  .ch_en      (cfg_q[N_CH-1:0]),
  .cnt        (cnt),
  .period_act (period_act),
  .on_act     (on_act)
);

// File: tb/tb_servo_pwm_bank.sv
module tb_servo_pwm_bank;
  localparam int N   = 8;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam logic [DW-1:0] GLB = DW'(1) << N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  servo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  servo_pwm_bank #(.N_CH(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (addr),
    .reg_wdata (wdata),
    .reg_we    (we),
    .reg_rdata (rdata),
    .servo_o   (servo)
  );

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(int a, logic [DW-1:0] exp, string req);
    @(negedge clk);
    addr = AW'(a);
    #1 chk(req, $sformatf("read addr %0d", a), rdata, exp);
  endtask

  task automatic restart(logic [DW-1:0] cfg);
    wr(1, cfg & ~GLB);
    wr(1, cfg | GLB);
  endtask

  task automatic t_reset;
    for (int a = 0; a < N + 2; a++) rd(a, '0, "R1");
    chk("R1", "outputs after reset", DW'(servo), '0);
  endtask

  task automatic t_readback;
    wr(0, 32'd1000000); wr(2, 32'd75000); wr(9, 32'h1234);
    wr(40, 32'hABCD);
    wr(1, 32'hFFFF_FFFF);
    rd(0, 32'd1000000, "R2");
    rd(2, 32'd75000, "R2");
    rd(9, 32'h1234, "R2");
    rd(1, 32'h1FF, "R2 config mask");
    rd(40, '0, "R2 unmapped");
    wr(1, '0);
    rd(1, '0, "R2");
  endtask

  task automatic t_frame;
    wr(0, 10); wr(2, 3); wr(3, 5); wr(4, 7); wr(9, 12);
    restart(32'h07);
    for (int i = 0; i < 25; i++) begin
      logic [N-1:0] e;
      e = '0;
      e[0] = (i % 10) < 3;
      e[1] = (i % 10) < 5;
      e[2] = (i % 10) < 7;
      @(negedge clk);
      chk("R3 R4 R5", $sformatf("frame tick %0d", i), DW'(servo), DW'(e));
    end
  endtask

  task automatic t_chan;
    wr(0, 8); wr(2, 2); wr(3, 2);
    restart(32'h02);
    for (int i = 0; i < 16; i++) begin
      logic [N-1:0] e;
      e = '0;
      e[1] = (i % 8) < 2;
      @(negedge clk);
      chk("R5", $sformatf("channel gate tick %0d", i), DW'(servo), DW'(e));
    end
  endtask

  task automatic t_midframe;
    wr(0, 10); wr(2, 3);
    restart(32'h01);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7", $sformatf("before write tick %0d", i), DW'(servo), DW'(i < 3));
    end
    wr(2, 7);
    for (int j = 0; j < 14; j++) begin
      @(negedge clk);
      chk("R7", $sformatf("after write step %0d", j), DW'(servo),
          DW'(j >= 4 && (j - 4) < 7));
    end
  endtask

  task automatic t_period;
    wr(0, 10); wr(2, 3);
    restart(32'h01);
    for (int i = 0; i < 2; i++) @(negedge clk);
    wr(0, 6);
    for (int j = 0; j < 19; j++) begin
      @(negedge clk);
      chk("R10", $sformatf("period change step %0d", j), DW'(servo),
          DW'(j >= 7 && ((j - 7) % 6) < 3));
    end
  endtask

  task automatic t_extremes;
    wr(0, 10); wr(2, 10); wr(3, 0); wr(4, 25);
    restart(32'h07);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R8 R9", $sformatf("extreme tick %0d", i), DW'(servo), DW'(8'b0000_0101));
    end
  endtask

  task automatic t_global;
    wr(0, 10); wr(2, 4);
    restart(32'h01);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R6", $sformatf("running tick %0d", i), DW'(servo), DW'(i < 4));
    end
    wr(1, 32'h01);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R6", $sformatf("global off tick %0d", i), DW'(servo), '0);
    end
    wr(1, GLB | 32'h01);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R6", $sformatf("re-enable tick %0d", i), DW'(servo), DW'(i < 4));
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_readback();
    t_frame();
    t_chan();
    t_midframe();
    t_period();
    t_extremes();
    t_global();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule